// File: doc/BRIEF.md
# Dual-Table Coefficient Store

This block keeps two independent filter coefficient tables in one 16-kbit storage array. Each of its two read ports has its own clock, enable and tap address, and it can reach only its own table. Port A always reads the lower half of the array and port B always reads the upper half. The port identity supplies the top bit of the physical address. The array is filled at elaboration from a computed constant image, so with writes disabled the block acts as a dual-port ROM.

Coefficient sets are symmetric, so tap `n` of an N-tap set holds the same value as tap `N-1-n`. When folding is on, each read port maps the requested tap onto the lower half of the set, and only about half the words per table are stored. A parameter can add a write port. It carries a table-select bit, a stored-word index and data, and it is clocked by the clock of one read port chosen by a parameter. Reads are plain enable-qualified accesses with a fixed one-cycle latency, and there is no back-pressure path. If the word count of a table, rounded up to a power of two, times the data width exceeds half of the array (8192 bits), the configuration is rejected at elaboration.

Top module: `coef_dual_table`

## Requirements
- R1: While a port's reset is low, and after its release until that port's first enabled read, its data output is zero.
- R2: A read has one cycle of latency. Data is captured on the rising edge of the port's clock at which its enable is high, and it appears after that edge and not before.
- R3: On a rising edge where a port's enable is low, that port's data output keeps its previous value, even when the tap address changes.
- R4: Before any write, stored word `i` of table `t` (table 0 for port A, table 1 for port B) equals `(37*i + 11 + 1000*t) mod 2^WIDTH`.
- R5: With FOLD=1, tap `n` (`n < TAPS`) reads stored word `min(n, TAPS-1-n)`. With FOLD=0, it reads stored word `n`.
- R6: The two ports run on unrelated clocks and read concurrently, and each returns correct words from its own table.
- R7: When WRITABLE=1, a write with `wr_en` high on a rising edge of the selected clock (port A clock when WR_ON_B=0) stores `wr_data` at stored word `wr_idx` of the table chosen by `wr_sel` (0 = table A, 1 = table B). The new value is returned by every later read of a tap that maps to that word.
- R8: A write never changes any word of the table that `wr_sel` did not choose.
- R9: If the write-side port reads the word being written in the same cycle, it returns the new data (write-first).
- R10: When WRITABLE=0, the write inputs have no effect on the contents of either table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock of read port A |
| rst_a_n | input | 1 | Active-low asynchronous reset of port A's output register |
| a_en | input | 1 | Read enable of port A |
| a_tap | input | TAW | Tap address of port A (table 0) |
| a_data | output | WIDTH | Registered read data of port A |
| clk_b | input | 1 | Clock of read port B |
| rst_b_n | input | 1 | Active-low asynchronous reset of port B's output register |
| b_en | input | 1 | Read enable of port B |
| b_tap | input | TAW | Tap address of port B (table 1) |
| b_data | output | WIDTH | Registered read data of port B |
| wr_en | input | 1 | Write strobe, sampled on the selected read clock |
| wr_sel | input | 1 | Table to update: 0 = table A, 1 = table B |
| wr_idx | input | IAW | Stored-word index inside the chosen table |
| wr_data | input | WIDTH | Coefficient value to store |

## Verification
The main instance uses WIDTH=12, TAPS=10, FOLD=1, WRITABLE=1 and writes on port A's clock. With ten taps and five stored words per table, every fold pair, including the middle pair 4/5 and the outer pair 0/9, is visited. Both tables are small enough that every tap of each can be read in parallel on the two unrelated clocks. Because writes are on port A's clock, the same-cycle write-first collision can be seen on port A, and a write into table B is seen across the clock boundary on port B. A second instance uses WIDTH=12, TAPS=8, FOLD=0, WRITABLE=0. It covers unfolded addressing and shows that the write pins are ignored in ROM mode.

// File: rtl/coef_pkg.sv
package coef_pkg;

  // Capacity of the shared array and of each table half.
  localparam int ARRAY_BITS = 16384;
  localparam int HALF_BITS  = ARRAY_BITS / 2;

  // Constant image word for table t, stored index i (truncated by caller).
  function automatic int image_word(input int t, input int i);
    return 37 * i + 11 + 1000 * t;
  endfunction

  // Address width with a floor of one bit.
  function automatic int addr_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/coef_tap_fold.sv
module coef_tap_fold #(
  parameter int TAPS = 64,
  parameter bit FOLD = 1'b1,
  parameter int TAW  = 6,
  parameter int IAW  = 5
) (
  input  logic [TAW-1:0] tap,
  output logic [IAW-1:0] idx
);

  localparam int STORED = FOLD ? (TAPS + 1) / 2 : TAPS;

  generate
    if (FOLD) begin : g_fold
      // Upper taps mirror onto the lower half of the symmetric set.
      always_comb begin
        if (int'(tap) >= STORED) idx = IAW'(TAPS - 1 - int'(tap));
        else                     idx = IAW'(tap);
      end
    end else begin : g_flat
      assign idx = IAW'(tap);
    end
  endgenerate

endmodule

// File: rtl/coef_store.sv
module coef_store #(
  parameter int WIDTH    = 16,
  parameter int IAW      = 5,
  parameter bit WRITABLE = 1'b1,
  parameter int WR_PORT  = 0
) (
  input  logic [1:0]            clk,
  input  logic [1:0]            rst_n,
  input  logic [1:0]            en,
  input  logic [1:0][IAW-1:0]   idx,
  output logic [WIDTH-1:0]      dout_a,
  output logic [WIDTH-1:0]      dout_b,
  input  logic                  we,
  input  logic                  wsel,
  input  logic [IAW-1:0]        widx,
  input  logic [WIDTH-1:0]      wdata
);

  localparam int HALF  = 1 << IAW;
  localparam int DEPTH = 2 * HALF;

  typedef logic [WIDTH-1:0] image_t [DEPTH];

  function automatic image_t build_image();
    image_t img;
    for (int a = 0; a < DEPTH; a++)
      img[a] = WIDTH'(coef_pkg::image_word(a / HALF, a % HALF));
    return img;
  endfunction

  image_t mem = build_image();

  generate
    for (genvar p = 0; p < 2; p++) begin : g_port
      logic [WIDTH-1:0] q_r;
      logic [IAW:0]     addr;
      // Port identity is the top address bit: A -> lower half, B -> upper half.
      assign addr = {1'(p), idx[p]};

      if (WRITABLE && p == WR_PORT) begin : g_wr
        always_ff @(posedge clk[p]) begin
          if (we) mem[{wsel, widx}] <= wdata;
        end

        always_ff @(posedge clk[p] or negedge rst_n[p]) begin
          if (!rst_n[p])  q_r <= '0;
          else if (en[p]) q_r <= (we && wsel == 1'(p) && widx == idx[p]) ? wdata : mem[addr];
        end

        // R9: same-cycle read of the word being written returns the new value
        p_write_first_r9: assert property (@(posedge clk[p]) disable iff (!rst_n[p])
          (en[p] && we && wsel == 1'(p) && widx == idx[p]) |=> (q_r == $past(wdata)));
      end else begin : g_rd
        always_ff @(posedge clk[p] or negedge rst_n[p]) begin
          if (!rst_n[p])  q_r <= '0;
          else if (en[p]) q_r <= mem[addr];
        end
      end

      // R3: an idle port keeps its output
      p_hold_r3: assert property (@(posedge clk[p]) disable iff (!rst_n[p])
        !en[p] |=> $stable(q_r));
    end

    if (!WRITABLE) begin : g_rom
      logic unused_wr;
      assign unused_wr = ^{we, wsel, widx, wdata};
    end
  endgenerate

  assign dout_a = g_port[0].q_r;
  assign dout_b = g_port[1].q_r;

endmodule

// File: rtl/coef_dual_table.sv
module coef_dual_table #(
  parameter int WIDTH    = 16,
  parameter int TAPS     = 64,
  parameter bit FOLD     = 1'b1,
  parameter bit WRITABLE = 1'b1,
  parameter bit WR_ON_B  = 1'b0,
  localparam int STORED  = FOLD ? (TAPS + 1) / 2 : TAPS,
  localparam int TAW     = coef_pkg::addr_bits(TAPS),
  localparam int IAW     = coef_pkg::addr_bits(STORED)
) (
  input  logic             clk_a,
  input  logic             rst_a_n,
  input  logic             a_en,
  input  logic [TAW-1:0]   a_tap,
  output logic [WIDTH-1:0] a_data,
  input  logic             clk_b,
  input  logic             rst_b_n,
  input  logic             b_en,
  input  logic [TAW-1:0]   b_tap,
  output logic [WIDTH-1:0] b_data,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [IAW-1:0]   wr_idx,
  input  logic [WIDTH-1:0] wr_data
);

  localparam int HALF = 1 << IAW;

  generate
    if (HALF * WIDTH > coef_pkg::HALF_BITS) begin : g_too_big
      $error("coef_dual_table: one table needs more than half of the shared array");
    end
  endgenerate

  logic [1:0]           clk_v;
  logic [1:0]           rst_v;
  logic [1:0]           en_v;
  logic [1:0][TAW-1:0]  taps;
  logic [1:0][IAW-1:0]  idx;

  assign clk_v = {clk_b, clk_a};
  assign rst_v = {rst_b_n, rst_a_n};
  assign en_v  = {b_en, a_en};
  assign taps  = {b_tap, a_tap};

  generate
    for (genvar p = 0; p < 2; p++) begin : g_fold
      coef_tap_fold #(
        .TAPS (TAPS),
        .FOLD (FOLD),
        .TAW  (TAW),
        .IAW  (IAW)
      ) u_fold (
        .tap (taps[p]),
        .idx (idx[p])
      );

      // R5: a valid tap lands inside the stored part of its table
      p_fold_in_range_r5: assert property (@(posedge clk_v[p]) disable iff (!rst_v[p])
        (en_v[p] && int'(taps[p]) < TAPS) |-> (int'(idx[p]) < STORED));

      // R5: stored index is the tap itself or its mirror
      p_fold_mirror_r5: assert property (@(posedge clk_v[p]) disable iff (!rst_v[p])
        (en_v[p] && int'(taps[p]) < TAPS) |->
          (int'(idx[p]) == int'(taps[p]) || int'(idx[p]) == TAPS - 1 - int'(taps[p])));
    end
  endgenerate

  coef_store #(
    .WIDTH    (WIDTH),
    .IAW      (IAW),
    .WRITABLE (WRITABLE),
    .WR_PORT  (WR_ON_B ? 1 : 0)
  ) u_store (
    .clk    (clk_v),
    .rst_n  (rst_v),
    .en     (en_v),
    .idx    (idx),
    .dout_a (a_data),
    .dout_b (b_data),
    .we     (wr_en),
    .wsel   (wr_sel),
    .widx   (wr_idx),
    .wdata  (wr_data)
  );

endmodule

// File: tb/coef_dual_table_tb.sv
module coef_dual_table_tb;

  localparam int W    = 12;
  localparam int TAPS = 10;
  localparam int TAW  = 4;
  localparam int IAW  = 3;
  localparam int FTAW = 3;

  // {tap, table, expected stored index}
  localparam int VEC [10][3] = '{
    '{0, 0, 0}, '{9, 0, 0}, '{4, 0, 4}, '{5, 0, 4}, '{2, 1, 2},
    '{7, 1, 2}, '{3, 1, 3}, '{6, 1, 3}, '{1, 0, 1}, '{8, 1, 1}
  };

  logic clk_a = 0, clk_b = 0;
  logic rst_a_n = 0, rst_b_n = 0;
  logic a_en = 0, b_en = 0;
  logic [TAW-1:0] a_tap = '0, b_tap = '0;
  logic [W-1:0] a_data, b_data;
  logic wr_en = 0, wr_sel = 0;
  logic [IAW-1:0] wr_idx = '0;
  logic [W-1:0] wr_data = '0;

  logic fa_en = 0, fb_en = 0;
  logic [FTAW-1:0] fa_tap = '0, fb_tap = '0;
  logic [W-1:0] fa_data, fb_data;
  logic f_wr_en = 0, f_wr_sel = 0;
  logic [FTAW-1:0] f_wr_idx = '0;
  logic [W-1:0] f_wr_data = '0;

  int n_chk = 0, n_bad = 0;

  always #10 clk_a = ~clk_a;
  always #17 clk_b = ~clk_b;

  coef_dual_table #(.WIDTH(W), .TAPS(TAPS), .FOLD(1'b1), .WRITABLE(1'b1), .WR_ON_B(1'b0)) u_dut (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .a_en(a_en), .a_tap(a_tap), .a_data(a_data),
    .clk_b(clk_b), .rst_b_n(rst_b_n), .b_en(b_en), .b_tap(b_tap), .b_data(b_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data));

  coef_dual_table #(.WIDTH(W), .TAPS(8), .FOLD(1'b0), .WRITABLE(1'b0), .WR_ON_B(1'b0)) u_flat (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .a_en(fa_en), .a_tap(fa_tap), .a_data(fa_data),
    .clk_b(clk_b), .rst_b_n(rst_b_n), .b_en(fb_en), .b_tap(fb_tap), .b_data(fb_data),
    .wr_en(f_wr_en), .wr_sel(f_wr_sel), .wr_idx(f_wr_idx), .wr_data(f_wr_data));

  function automatic int img(input int t, input int i);
    return (37 * i + 11 + 1000 * t) % (1 << W);
  endfunction

  function automatic int fold(input int n);
    return (n < TAPS - 1 - n) ? n : TAPS - 1 - n;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd_a(input int tap, output int val);
    @(negedge clk_a); a_en = 1; a_tap = TAW'(tap);
    @(negedge clk_a); a_en = 0; val = int'(a_data);
  endtask

  task automatic rd_b(input int tap, output int val);
    @(negedge clk_b); b_en = 1; b_tap = TAW'(tap);
    @(negedge clk_b); b_en = 0; val = int'(b_data);
  endtask

  task automatic rd_fa(input int tap, output int val);
    @(negedge clk_a); fa_en = 1; fa_tap = FTAW'(tap);
    @(negedge clk_a); fa_en = 0; val = int'(fa_data);
  endtask

  task automatic rd_fb(input int tap, output int val);
    @(negedge clk_b); fb_en = 1; fb_tap = FTAW'(tap);
    @(negedge clk_b); fb_en = 0; val = int'(fb_data);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk_a);
    chk("R1 reset a", int'(a_data), 0);
    chk("R1 reset b", int'(b_data), 0);
    rst_a_n = 1; rst_b_n = 1;
    repeat (2) @(negedge clk_b);
    chk("R1 after release a", int'(a_data), 0);
    chk("R1 after release b", int'(b_data), 0);
    chk("R1 after release flat", int'(fb_data), 0);

    // R6 / R4: every tap of both tables, concurrently on the two clocks
    fork
      for (int n = 0; n < TAPS; n++) begin
        int va;
        rd_a(n, va);
        chk("R6 R4 port A sweep", va, img(0, fold(n)));
      end
      for (int n = 0; n < TAPS; n++) begin
        int vb;
        rd_b(n, vb);
        chk("R6 R4 port B sweep", vb, img(1, fold(n)));
      end
    join

    // R5: vector table of fold pairs
    for (int k = 0; k < 10; k++) begin
      if (VEC[k][1] == 0) rd_a(VEC[k][0], v);
      else                rd_b(VEC[k][0], v);
      chk("R5 folded tap", v, img(VEC[k][1], VEC[k][2]));
    end

    // R3: hold while enable low and tap moves
    rd_a(3, v);
    @(negedge clk_a); a_tap = 0;
    @(negedge clk_a); a_tap = 7;
    @(negedge clk_a);
    chk("R3 hold", int'(a_data), img(0, 3));

    // R2: one-cycle latency
    @(negedge clk_a); a_en = 1; a_tap = 1;
    #1 chk("R2 not before edge", int'(a_data), img(0, 3));
    @(negedge clk_a); a_en = 0;
    chk("R2 after edge", int'(a_data), img(0, 1));

    // R7: write table B on clock A, read on clock B
    @(negedge clk_a); wr_en = 1; wr_sel = 1; wr_idx = 2; wr_data = 12'hABC;
    @(negedge clk_a); wr_en = 0;
    rd_b(2, v); chk("R7 write visible", v, 12'hABC);
    rd_b(7, v); chk("R7 write visible at mirror", v, 12'hABC);
    for (int n = 0; n < TAPS; n++) begin
      rd_a(n, v);
      chk("R8 table A untouched", v, img(0, fold(n)));
    end

    // R9: write-first collision on port A
    @(negedge clk_a); wr_en = 1; wr_sel = 0; wr_idx = 3; wr_data = 12'h5A5; a_en = 1; a_tap = 3;
    @(negedge clk_a); wr_en = 0; a_en = 0;
    chk("R9 write-first", int'(a_data), 12'h5A5);
    rd_b(3, v); chk("R8 table B untouched", v, img(1, 3));
    rd_a(6, v); chk("R7 rewrite at mirror", v, 12'h5A5);

    // R10: ROM instance ignores write pins
    rd_fb(6, v); chk("R5 unfolded tap", v, img(1, 6));
    @(negedge clk_a); f_wr_en = 1; f_wr_sel = 1; f_wr_idx = 6; f_wr_data = 12'h111;
    @(negedge clk_a); f_wr_sel = 0; f_wr_idx = 5;
    @(negedge clk_a); f_wr_en = 0;
    rd_fb(6, v); chk("R10 ROM table B unchanged", v, img(1, 6));
    rd_fa(5, v); chk("R10 ROM table A unchanged", v, img(0, 5));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule